// File: doc/BRIEF.md
# Staggered Half-Word Pipelined ALU

This unit performs 32-bit integer addition, subtraction and bitwise logic on a fast clock. It splits each operation over three consecutive fast cycles. The first cycle produces the lower 16 bits. The second produces the upper 16 bits, using the carry that the lower half generated. The third produces the condition flags. Because of this split, only one 16-bit adder and its operand multiplexers have to settle within a single fast cycle.

Each half of the result is published on its own port as soon as it exists. A consumer such as an address generator can therefore start on the lower half before the upper half is ready. An operation flagged as dependent takes its first operand from the most recently issued operation's result, one half at a time. Each half arrives exactly when the dependent operation's matching stage needs it, so a chain of dependent additions issues on every fast cycle without stalling.

Top module: `staggered_alu`

## Requirements
- R1: The reset `rst_n` is synchronous and active-low. While it is sampled low, it clears `lo_valid`, `hi_valid` and `flg_valid`, both result halves and all four flags to 0.
- R2: An operation issued with `iss_valid` high at clock edge N drives its result bits 15:0 on `lo_data`, with `lo_valid` high, in the cycle after edge N.
- R3: The same operation drives its result bits 31:16 on `hi_data`, with `hi_valid` high, in the cycle after edge N+1. For additions and subtractions the upper half takes in the carry-out of the lower half.
- R4: The same operation drives its flags, with `flg_valid` high, in the cycle after edge N+2.
- R5: `iss_op` encodes 0 = ADD (a+b), 1 = SUB (a + ~b + 1, two's complement), 2 = AND, 3 = OR and 4 = XOR. Codes 5 to 7 act as ADD.
- R6: The flags are defined as follows:
  - `flg_zero` is 1 when all 32 result bits are 0.
  - `flg_sign` is result bit 31.
  - `flg_carry` is the carry-out of bit 31. For SUB it is 1 when no borrow occurs.
  - `flg_ovf` is signed overflow of ADD or SUB.
  - For AND, OR and XOR, `flg_carry` and `flg_ovf` are 0.
- R7: With `iss_dep` high, operand A is replaced, half by half, with the result of the most recently issued operation. This works both back to back on consecutive cycles and after idle gaps.
- R8: With `iss_dep` low, `iss_a` is used unchanged, even right after another operation.
- R9: A cycle with `iss_valid` low issues nothing. The valid outputs for that slot stay low, and `lo_data`, `hi_data` and the flags keep their last values regardless of `iss_op`, `iss_dep`, `iss_a` and `iss_b`.
- R10: Logic operations pass no carry between halves. For example, AND of 0x0000FFFF with 0x0000FFFF yields 0x0000FFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Synchronous active-low reset |
| iss_valid | input | 1 | Issue an operation this cycle |
| iss_op | input | 3 | Operation code |
| iss_dep | input | 1 | Take operand A from the previous result |
| iss_a | input | 32 | Operand A from the register file |
| iss_b | input | 32 | Operand B |
| lo_valid | output | 1 | `lo_data` holds a new lower half |
| lo_data | output | 16 | Result bits 15:0 |
| hi_valid | output | 1 | `hi_data` holds a new upper half |
| hi_data | output | 16 | Result bits 31:16 |
| flg_valid | output | 1 | Flags are new |
| flg_zero | output | 1 | Result is zero |
| flg_carry | output | 1 | Carry-out of bit 31 |
| flg_sign | output | 1 | Result bit 31 |
| flg_ovf | output | 1 | Signed overflow |

## Verification
The hardest case to reach is a dependent chain in which every link issues on the very next cycle while the lower-half carry ripples into the upper half. In that case the upper-half bypass must pick up a value registered only one edge earlier. The stimulus issues runs of dependent additions whose lower halves sit near 0xFFFF, so each link crosses the half boundary. It also mixes dependent issues after idle gaps, and idle cycles carrying misleading operands, into a long pseudo-random stream. The scoreboard holds the expected halves and flags of every issued operation and compares them as each port reports them.

// File: rtl/sa_pkg.sv
// Package: shared operation codes for the staggered ALU.
// Assumes a 3-bit operation field. Unlisted codes are handled as ADD.
package sa_pkg;
    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_AND = 3'd2,
        OP_OR  = 3'd3,
        OP_XOR = 3'd4
    } sa_op_e;

    // True for the bitwise operations, which carry nothing between halves.
    function automatic logic sa_is_logic(sa_op_e op);
        return (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);
    endfunction
endpackage

// File: rtl/sa_half_slice.sv
// Module: one half-width arithmetic/logic slice (combinational).
// Assumes the caller supplies carry-in: 1 for the lower half of SUB,
// the lower half's carry-out for the upper half. Bitwise ops ignore cin
// and report no carry.
module sa_half_slice
    import sa_pkg::*;
#(
    parameter int HW = 16
) (
    input  sa_op_e          op,
    input  logic [HW-1:0]   a,
    input  logic [HW-1:0]   b,
    input  logic            cin,
    output logic [HW-1:0]   res,
    output logic            cout
);
    localparam int SW = HW + 1;

    logic [HW-1:0] b_x;
    logic [SW-1:0] sum;

    // Purpose: select operation and form result and carry-out.
    always_comb begin
        b_x = (op == OP_SUB) ? ~b : b;
        sum = {1'b0, a} + {1'b0, b_x} + SW'(cin);
        case (op)
            OP_AND:  begin res = a & b; cout = 1'b0; end
            OP_OR:   begin res = a | b; cout = 1'b0; end
            OP_XOR:  begin res = a ^ b; cout = 1'b0; end
            default: begin res = sum[HW-1:0]; cout = sum[HW]; end
        endcase
    end
endmodule

// File: rtl/sa_lo_stage.sv
// Module: first fast-cycle stage. Computes the lower half and registers it
// together with the upper operands, the carry and the control bits.
// Assumes the lower result register holds its value over idle cycles,
// so the dependency bypass always sees the latest issued result.
module sa_lo_stage
    import sa_pkg::*;
#(
    parameter int HW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_vld,
    input  sa_op_e          in_op,
    input  logic            in_dep,
    input  logic [2*HW-1:0] in_a,
    input  logic [2*HW-1:0] in_b,
    output logic            s1_vld,
    output sa_op_e          s1_op,
    output logic            s1_dep,
    output logic [HW-1:0]   s1_ahi,
    output logic [HW-1:0]   s1_bhi,
    output logic            s1_cy,
    output logic [HW-1:0]   s1_lo
);
    logic [HW-1:0] a_eff;
    logic [HW-1:0] lo_res;
    logic          lo_cout;

    // Purpose: bypass mux choosing operand A's lower half.
    always_comb a_eff = in_dep ? s1_lo : in_a[HW-1:0];

    sa_half_slice #(.HW(HW)) u_slice (
        .op   (in_op),
        .a    (a_eff),
        .b    (in_b[HW-1:0]),
        .cin  (in_op == OP_SUB),
        .res  (lo_res),
        .cout (lo_cout)
    );

    // Purpose: stage-1 pipeline register, loaded only on a valid issue.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_vld <= 1'b0;
            s1_op  <= OP_ADD;
            s1_dep <= 1'b0;
            s1_ahi <= '0;
            s1_bhi <= '0;
            s1_cy  <= 1'b0;
            s1_lo  <= '0;
        end else begin
            s1_vld <= in_vld;
            if (in_vld) begin
                s1_op  <= in_op;
                s1_dep <= in_dep;
                s1_ahi <= in_a[2*HW-1:HW];
                s1_bhi <= in_b[2*HW-1:HW];
                s1_cy  <= lo_cout;
                s1_lo  <= lo_res;
            end
        end
    end

    // R10: a bitwise op never hands a carry to the upper half.
    assert_lo_logic_no_carry_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_vld && sa_is_logic(s1_op)) |-> !s1_cy);
endmodule

// File: rtl/sa_hi_stage.sv
// Module: second fast-cycle stage. Computes the upper half with the carry
// from stage 1 and derives signed overflow.
// Assumes the upper result register holds over idle slots for the bypass.
module sa_hi_stage
    import sa_pkg::*;
#(
    parameter int HW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          s1_vld,
    input  sa_op_e        s1_op,
    input  logic          s1_dep,
    input  logic [HW-1:0] s1_ahi,
    input  logic [HW-1:0] s1_bhi,
    input  logic          s1_cy,
    input  logic [HW-1:0] s1_lo,
    output logic          s2_vld,
    output logic [HW-1:0] s2_lo,
    output logic [HW-1:0] s2_hi,
    output logic          s2_cy,
    output logic          s2_ov
);
    logic [HW-1:0] a_eff;
    logic [HW-1:0] b_x;
    logic [HW-1:0] hi_res;
    logic          hi_cout;
    logic          ov;

    // Purpose: bypass mux choosing operand A's upper half.
    always_comb a_eff = s1_dep ? s2_hi : s1_ahi;

    sa_half_slice #(.HW(HW)) u_slice (
        .op   (s1_op),
        .a    (a_eff),
        .b    (s1_bhi),
        .cin  (s1_cy),
        .res  (hi_res),
        .cout (hi_cout)
    );

    // Purpose: signed overflow from the sign bits of operands and result.
    always_comb begin
        b_x = (s1_op == OP_SUB) ? ~s1_bhi : s1_bhi;
        ov  = !sa_is_logic(s1_op) && (a_eff[HW-1] == b_x[HW-1])
              && (hi_res[HW-1] != a_eff[HW-1]);
    end

    // Purpose: stage-2 pipeline register, loaded when stage 1 is valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_vld <= 1'b0;
            s2_lo  <= '0;
            s2_hi  <= '0;
            s2_cy  <= 1'b0;
            s2_ov  <= 1'b0;
        end else begin
            s2_vld <= s1_vld;
            if (s1_vld) begin
                s2_lo <= s1_lo;
                s2_hi <= hi_res;
                s2_cy <= hi_cout;
                s2_ov <= ov;
            end
        end
    end

    // R6: bitwise ops leave carry and overflow clear.
    assert_hi_logic_no_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_vld && sa_is_logic(s1_op)) |=> (!s2_cy && !s2_ov));
endmodule

// File: rtl/sa_flag_stage.sv
// Module: third fast-cycle stage. Registers zero, carry, sign and overflow
// once both halves are known. Assumes flags hold over idle slots.
module sa_flag_stage #(
    parameter int HW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          s2_vld,
    input  logic [HW-1:0] s2_lo,
    input  logic [HW-1:0] s2_hi,
    input  logic          s2_cy,
    input  logic          s2_ov,
    output logic          s3_vld,
    output logic          f_z,
    output logic          f_c,
    output logic          f_s,
    output logic          f_v
);
    // Purpose: stage-3 flag register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s3_vld <= 1'b0;
            f_z    <= 1'b0;
            f_c    <= 1'b0;
            f_s    <= 1'b0;
            f_v    <= 1'b0;
        end else begin
            s3_vld <= s2_vld;
            if (s2_vld) begin
                f_z <= (s2_lo == '0) && (s2_hi == '0);
                f_c <= s2_cy;
                f_s <= s2_hi[HW-1];
                f_v <= s2_ov;
            end
        end
    end
endmodule

// File: rtl/staggered_alu.sv
// Module: top of the staggered half-word ALU. Chains the lower, upper and
// flag stages on one fast clock. Assumes synchronous active-low reset and
// an issue slot every cycle with no back-pressure.
module staggered_alu
    import sa_pkg::*;
#(
    parameter int HALF_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                iss_valid,
    input  logic [2:0]          iss_op,
    input  logic                iss_dep,
    input  logic [2*HALF_W-1:0] iss_a,
    input  logic [2*HALF_W-1:0] iss_b,
    output logic                lo_valid,
    output logic [HALF_W-1:0]   lo_data,
    output logic                hi_valid,
    output logic [HALF_W-1:0]   hi_data,
    output logic                flg_valid,
    output logic                flg_zero,
    output logic                flg_carry,
    output logic                flg_sign,
    output logic                flg_ovf
);
    localparam int WORD_W = 2 * HALF_W;

    sa_op_e              s1_op;
    logic                s1_dep;
    logic [HALF_W-1:0]   s1_ahi;
    logic [HALF_W-1:0]   s1_bhi;
    logic                s1_cy;
    logic [HALF_W-1:0]   s2_lo;
    logic                s2_cy;
    logic                s2_ov;
    logic [WORD_W-1:0]   a_w;

    // Purpose: name the operand bus at word width.
    always_comb a_w = iss_a;

    sa_lo_stage #(.HW(HALF_W)) u_lo (
        .clk    (clk),
        .rst_n  (rst_n),
        .in_vld (iss_valid),
        .in_op  (sa_op_e'(iss_op)),
        .in_dep (iss_dep),
        .in_a   (a_w),
        .in_b   (iss_b),
        .s1_vld (lo_valid),
        .s1_op  (s1_op),
        .s1_dep (s1_dep),
        .s1_ahi (s1_ahi),
        .s1_bhi (s1_bhi),
        .s1_cy  (s1_cy),
        .s1_lo  (lo_data)
    );

    sa_hi_stage #(.HW(HALF_W)) u_hi (
        .clk    (clk),
        .rst_n  (rst_n),
        .s1_vld (lo_valid),
        .s1_op  (s1_op),
        .s1_dep (s1_dep),
        .s1_ahi (s1_ahi),
        .s1_bhi (s1_bhi),
        .s1_cy  (s1_cy),
        .s1_lo  (lo_data),
        .s2_vld (hi_valid),
        .s2_lo  (s2_lo),
        .s2_hi  (hi_data),
        .s2_cy  (s2_cy),
        .s2_ov  (s2_ov)
    );

    sa_flag_stage #(.HW(HALF_W)) u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .s2_vld (hi_valid),
        .s2_lo  (s2_lo),
        .s2_hi  (hi_data),
        .s2_cy  (s2_cy),
        .s2_ov  (s2_ov),
        .s3_vld (flg_valid),
        .f_z    (flg_zero),
        .f_c    (flg_carry),
        .f_s    (flg_sign),
        .f_v    (flg_ovf)
    );

    // R3: every lower half is followed by its upper half one cycle later.
    assert_hi_follows_lo_R3: assert property (@(posedge clk) disable iff (!rst_n)
        lo_valid |=> hi_valid);

    // R4: flags follow the upper half one cycle later.
    assert_flags_follow_hi_R4: assert property (@(posedge clk) disable iff (!rst_n)
        hi_valid |=> flg_valid);

    // R6: the sign flag matches bit 31 of the upper half just published.
    assert_sign_is_top_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        flg_valid |-> (flg_sign == $past(hi_data[HALF_W-1])));

    // R9: an idle issue slot leaves the lower result untouched.
    assert_idle_holds_lo_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !iss_valid |=> $stable(lo_data));
endmodule

// File: tb/staggered_alu_tb.sv
module staggered_alu_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        iss_valid = 1'b0;
    logic [2:0]  iss_op = 3'd0;
    logic        iss_dep = 1'b0;
    logic [31:0] iss_a = '0;
    logic [31:0] iss_b = '0;
    logic        lo_valid, hi_valid, flg_valid;
    logic [15:0] lo_data, hi_data;
    logic        flg_zero, flg_carry, flg_sign, flg_ovf;

    typedef struct {
        logic [31:0] res;
        logic        z, c, s, v;
        string       req;
    } exp_t;

    exp_t  lo_q[$];
    exp_t  hi_q[$];
    exp_t  fl_q[$];
    exp_t  last_e;
    logic [31:0] last_res = '0;
    int    n_chk = 0;
    int    n_fail = 0;
    bit    finished = 0;

    always #10 clk = ~clk;   // 50 MHz

    staggered_alu u_dut (
        .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_op(iss_op),
        .iss_dep(iss_dep), .iss_a(iss_a), .iss_b(iss_b),
        .lo_valid(lo_valid), .lo_data(lo_data), .hi_valid(hi_valid),
        .hi_data(hi_data), .flg_valid(flg_valid), .flg_zero(flg_zero),
        .flg_carry(flg_carry), .flg_sign(flg_sign), .flg_ovf(flg_ovf)
    );

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    // Reference model of the whole 32-bit operation (R5, R6).
    function automatic exp_t model(logic [2:0] op, logic [31:0] a, logic [31:0] b, string req);
        exp_t e;
        logic [32:0] s;
        e.req = req;
        e.c = 1'b0;
        e.v = 1'b0;
        case (op)
            3'd1: begin
                s = {1'b0, a} + {1'b0, ~b} + 33'd1;
                e.res = s[31:0]; e.c = s[32];
                e.v = (a[31] != b[31]) && (e.res[31] != a[31]);
            end
            3'd2: e.res = a & b;
            3'd3: e.res = a | b;
            3'd4: e.res = a ^ b;
            default: begin
                s = {1'b0, a} + {1'b0, b};
                e.res = s[31:0]; e.c = s[32];
                e.v = (a[31] == b[31]) && (e.res[31] != a[31]);
            end
        endcase
        e.z = (e.res == 32'd0);
        e.s = e.res[31];
        return e;
    endfunction

    // Driver: issue one operation and push its expectations.
    task automatic issue(logic [2:0] op, logic dep, logic [31:0] a, logic [31:0] b, string req);
        exp_t e;
        e = model(op, dep ? last_res : a, b, req);
        lo_q.push_back(e);
        hi_q.push_back(e);
        fl_q.push_back(e);
        last_res = e.res;
        last_e = e;
        iss_valid = 1'b1; iss_op = op; iss_dep = dep; iss_a = a; iss_b = b;
        @(negedge clk);
    endtask

    // Idle slot with misleading operands (R9).
    task automatic idle();
        iss_valid = 1'b0; iss_op = 3'd0; iss_dep = 1'b1;
        iss_a = $urandom; iss_b = $urandom;
        @(negedge clk);
    endtask

    // Monitor: compare each published half and flag set against the scoreboard.
    always @(negedge clk) begin
        if (rst_n) begin
            if (lo_valid) begin
                if (lo_q.size() == 0) chk("R2", "unexpected lo_valid", 32'd1, 32'd0);
                else begin
                    exp_t e;
                    e = lo_q.pop_front();
                    chk(e.req, "lo_data (R2)", {16'd0, lo_data}, {16'd0, e.res[15:0]});
                end
            end
            if (hi_valid) begin
                if (hi_q.size() == 0) chk("R3", "unexpected hi_valid", 32'd1, 32'd0);
                else begin
                    exp_t e;
                    e = hi_q.pop_front();
                    chk(e.req, "hi_data (R3)", {16'd0, hi_data}, {16'd0, e.res[31:16]});
                end
            end
            if (flg_valid) begin
                if (fl_q.size() == 0) chk("R4", "unexpected flg_valid", 32'd1, 32'd0);
                else begin
                    exp_t e;
                    e = fl_q.pop_front();
                    chk(e.req, "flags zcsv (R6)", {28'd0, flg_zero, flg_carry, flg_sign, flg_ovf},
                        {28'd0, e.z, e.c, e.s, e.v});
                end
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "valids", {29'd0, lo_valid, hi_valid, flg_valid}, 32'd0);
        chk("R1", "data", {lo_data, hi_data}, 32'd0);
        chk("R1", "flags", {28'd0, flg_zero, flg_carry, flg_sign, flg_ovf}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 carry across halves, R6 flag corners
        issue(3'd0, 1'b0, 32'h0000FFFF, 32'h00000001, "R3");
        issue(3'd0, 1'b0, 32'hFFFFFFFF, 32'h00000001, "R6");
        issue(3'd0, 1'b0, 32'h7FFFFFFF, 32'h00000001, "R6");
        issue(3'd1, 1'b0, 32'h00000005, 32'h00000005, "R5");
        issue(3'd1, 1'b0, 32'h00000003, 32'h00000005, "R5");
        issue(3'd1, 1'b0, 32'h80000000, 32'h00000001, "R6");
        // R10 logic ops keep halves apart
        issue(3'd2, 1'b0, 32'h0000FFFF, 32'h0000FFFF, "R10");
        issue(3'd3, 1'b0, 32'h0000FFFF, 32'h0000FFFF, "R10");
        issue(3'd4, 1'b0, 32'hA5A5FFFF, 32'h5A5A0001, "R10");
        // R7 back-to-back dependent chain crossing the half boundary
        issue(3'd0, 1'b0, 32'h0000FFF0, 32'h00000010, "R7");
        issue(3'd0, 1'b1, 32'hDEADBEEF, 32'h0000FFFF, "R7");
        issue(3'd0, 1'b1, 32'h12345678, 32'h0001FFFF, "R7");
        issue(3'd1, 1'b1, 32'h00000000, 32'h00000001, "R7");
        issue(3'd4, 1'b1, 32'hFFFFFFFF, 32'hFFFF0000, "R7");
        // R7 dependence after idle gap
        idle();
        idle();
        issue(3'd0, 1'b1, 32'h00000000, 32'h00008001, "R7");
        // R8 no dependence right after a result
        issue(3'd0, 1'b0, 32'h00001111, 32'h00002222, "R8");
        issue(3'd0, 1'b0, 32'h0000FFFF, 32'h0000FFFF, "R8");

        // Pseudo-random mix
        for (int i = 0; i < 80; i++) begin
            logic [31:0] a, b;
            a = $urandom;
            b = $urandom;
            if (($urandom % 3) == 0) a[15:0] = 16'hFFFF;
            if (($urandom % 7) == 0) idle();
            issue(3'($urandom % 5), 1'($urandom % 2), a, b, "R7");
        end

        // R9: idle cycles hold all outputs
        repeat (6) idle();
        chk("R9", "valids idle", {29'd0, lo_valid, hi_valid, flg_valid}, 32'd0);
        chk("R9", "held result", {hi_data, lo_data}, last_res);
        chk("R9", "held flags", {28'd0, flg_zero, flg_carry, flg_sign, flg_ovf},
            {28'd0, last_e.z, last_e.c, last_e.s, last_e.v});
        chk("R4", "scoreboard drained", lo_q.size() + hi_q.size() + fl_q.size(), 32'd0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL R2 watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule